// File: doc/BRIEF.md
# Keyed Overlay Mixer With Colour Table

This block sits in a video pixel pipeline and chooses, pixel by pixel, whether the main Y/Cb/Cr sample stream passes through or is replaced by an overlay colour. A key input makes that choice, and its active level can be set. A 3-bit overlay code picks one of eight programmable colours from a small table. Each colour holds one luma byte and two chroma bytes.

Two registered output paths leave the block. The encoder path feeds composite and S-video encoding, and the RGB path feeds the colour matrix. A control bit can switch off keying on the encoder path alone. When it is set, overlay graphics still reach the RGB output while the encoder keeps main video. A software-selected test mode replaces active video on both paths with colour bars: the table entries are shown in sequence, eight equal steps per active line, and no external data is needed.

The table and the three control bits are loaded through a simple byte-wide write port. Outside active video, main video always passes through.

Top module: `ovl_key_mixer`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are zero, every table byte is zero and all control bits are zero.
- R2: Both output paths and `out_act` are registered. The values on the outputs follow the inputs sampled one clock earlier.
- R3: A write to byte address 3*index+component loads one table byte. The component is 0 for Y, 1 for Cb and 2 for Cr. A pixel sampled in the same cycle as the write still sees the old byte, and the pixel sampled in the next cycle sees the new one.
- R4: With control bit 0 clear, key high during active video replaces the pixel on both paths with the table entry chosen by `ovl_code`. Key low passes main video.
- R5: With control bit 0 set, the key polarity is inverted: key low selects the overlay colour and key high passes main video.
- R6: With control bit 1 set, the encoder path ignores the key and carries main video, while the RGB path still shows the overlay colour.
- R7: With control bit 2 set, both paths show table entry k during active pixels k*S to k*S+S-1 of a line, where S = ACT_PIX/8. The step restarts at entry 0 at each rising edge of `pix_act` and holds entry 7 if the line runs long.
- R8: In colour bar mode, the key, the overlay code, the encoder key-off bit and the main pixel values have no effect on active-video output.
- R9: When `pix_act` is low, both paths carry the main pixel unchanged, whatever the key, overlay code or control bits.
- R10: The control bits are written at byte address 24 (bit0 key invert, bit1 encoder key off, bit2 colour bars). Writes to addresses 25 to 31 change neither the table nor the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_y | input | 8 | Main video luma |
| pix_cb | input | 8 | Main video blue colour difference |
| pix_cr | input | 8 | Main video red colour difference |
| pix_act | input | 1 | High during active video pixels |
| key_in | input | 1 | Overlay key |
| ovl_code | input | 3 | Overlay colour index |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| enc_y | output | 8 | Encoder path luma |
| enc_cb | output | 8 | Encoder path Cb |
| enc_cr | output | 8 | Encoder path Cr |
| rgb_y | output | 8 | RGB path luma |
| rgb_cb | output | 8 | RGB path Cb |
| rgb_cr | output | 8 | RGB path Cr |
| out_act | output | 1 | `pix_act` aligned with the outputs |

## Verification
A table write and a keyed pixel that reads the entry being written can fall in the same clock. The bench provokes this by issuing a write to the Cb byte of entry 2 while an active, keyed pixel with overlay code 2 is sampled. It judges the result by expecting the old colour on that output and the new colour on the following pixel. A second collision is the line start meeting a keyed pixel while colour bar mode is on. The bench checks that the bar sequence wins from its first pixel, on both paths.

// File: rtl/ovm_pkg.sv
package ovm_pkg;
   parameter int unsigned PIX_W  = 8;
   parameter int unsigned COMP_N = 3;

   typedef struct packed {
      logic [PIX_W-1:0] y;
      logic [PIX_W-1:0] cb;
      logic [PIX_W-1:0] cr;
   } ycc_t;

   typedef struct packed {
      logic bar_en;
      logic enc_key_off;
      logic key_inv;
   } mix_ctrl_t;

   localparam int unsigned CTRL_W = $bits(mix_ctrl_t);
endpackage

// File: rtl/ovm_lut.sv
module ovm_lut
   import ovm_pkg::*;
#(
   parameter int unsigned NCOL   = 8,
   parameter int unsigned ADDR_W = 5,
   localparam int unsigned CODE_W = $clog2(NCOL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PIX_W-1:0]  wdata,
   input  logic [CODE_W-1:0] code_a,
   input  logic [CODE_W-1:0] idx_b,
   output ycc_t              ent_a,
   output ycc_t              ent_b,
   output mix_ctrl_t         ctrl
);
   localparam int unsigned TBL_BYTES = COMP_N * NCOL;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(TBL_BYTES);

   if ((1 << CODE_W) != NCOL) begin : g_bad_ncol
      $error("ovm_lut: NCOL must be a power of two");
   end
   if ((1 << ADDR_W) <= TBL_BYTES) begin : g_bad_addr
      $error("ovm_lut: ADDR_W too narrow for table and control byte");
   end

   logic [PIX_W-1:0] mem_q [TBL_BYTES];
   ycc_t             ent [NCOL];
   mix_ctrl_t        ctrl_q;
   logic             armed_q;

   for (genvar b = 0; b < TBL_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem_q[b] <= '0;
         else if (we && addr == ADDR_W'(b))
            mem_q[b] <= wdata;
      end
   end

   for (genvar i = 0; i < NCOL; i++) begin : g_ent
      assign ent[i].y  = mem_q[COMP_N*i + 0];
      assign ent[i].cb = mem_q[COMP_N*i + 1];
      assign ent[i].cr = mem_q[COMP_N*i + 2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (we && addr == CTRL_ADDR)
         ctrl_q <= mix_ctrl_t'(wdata[CTRL_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   assign ent_a = ent[code_a];
   assign ent_b = ent[idx_b];
   assign ctrl  = ctrl_q;

   // R3
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && $past(we) && ($past(addr) < ADDR_W'(TBL_BYTES))
      |-> mem_q[$past(addr)] == $past(wdata));

   // R10
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && !($past(we) && $past(addr) == CTRL_ADDR)
      |-> $stable(ctrl_q));
endmodule

// File: rtl/ovm_bar_seq.sv
module ovm_bar_seq #(
   parameter int unsigned NCOL    = 8,
   parameter int unsigned ACT_PIX = 720,
   localparam int unsigned CODE_W = $clog2(NCOL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   output logic [CODE_W-1:0] idx
);
   localparam int unsigned STEP  = ACT_PIX / NCOL;
   localparam int unsigned CNT_W = (STEP > 1) ? $clog2(STEP) : 1;
   localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(STEP - 1);
   localparam logic [CODE_W-1:0] LAST_IDX = CODE_W'(NCOL - 1);

   if (STEP == 0 || (ACT_PIX % NCOL) != 0) begin : g_bad_len
      $error("ovm_bar_seq: ACT_PIX must be a nonzero multiple of NCOL");
   end

   logic              act_prev_q;
   logic              armed_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] idx_q;
   logic              first;
   logic [CNT_W-1:0]  cnt_c;
   logic [CODE_W-1:0] idx_c;

   assign first = act && !act_prev_q;
   assign cnt_c = first ? '0 : cnt_q;
   assign idx_c = first ? '0 : idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_prev_q <= 1'b0;
         cnt_q      <= '0;
         idx_q      <= '0;
         armed_q    <= 1'b0;
      end else begin
         armed_q    <= 1'b1;
         act_prev_q <= act;
         if (act) begin
            if (cnt_c == LAST_CNT) begin
               cnt_q <= '0;
               idx_q <= (idx_c == LAST_IDX) ? idx_c : idx_c + CODE_W'(1);
            end else begin
               cnt_q <= cnt_c + CNT_W'(1);
               idx_q <= idx_c;
            end
         end
      end
   end

   assign idx = idx_c;

   // R7
   bar_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && act && act_prev_q
      |-> (idx == $past(idx)) || (idx == $past(idx) + CODE_W'(1)));
endmodule

// File: rtl/ovm_path_sel.sv
module ovm_path_sel
   import ovm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  logic key_hit,
   input  logic key_off,
   input  logic bar_en,
   input  ycc_t main_px,
   input  ycc_t ovl_px,
   input  ycc_t bar_px,
   output ycc_t out_px
);
   ycc_t nxt;
   ycc_t q;
   logic armed_q;

   always_comb begin
      if (!act)
         nxt = main_px;
      else if (bar_en)
         nxt = bar_px;
      else if (key_hit && !key_off)
         nxt = ovl_px;
      else
         nxt = main_px;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= '0;
         armed_q <= 1'b0;
      end else begin
         q       <= nxt;
         armed_q <= 1'b1;
      end
   end

   assign out_px = q;

   // R9
   blank_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && !$past(act) |-> q == $past(main_px));
endmodule

// File: rtl/ovl_key_mixer.sv
module ovl_key_mixer
   import ovm_pkg::*;
#(
   parameter int unsigned NCOL        = 8,
   parameter int unsigned ACT_PIX     = 720,
   parameter bit          ENC_GATE_EN = 1'b1,
   localparam int unsigned CODE_W = $clog2(NCOL),
   localparam int unsigned ADDR_W = $clog2(COMP_N * NCOL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  pix_y,
   input  logic [PIX_W-1:0]  pix_cb,
   input  logic [PIX_W-1:0]  pix_cr,
   input  logic              pix_act,
   input  logic              key_in,
   input  logic [CODE_W-1:0] ovl_code,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [PIX_W-1:0]  cfg_wdata,
   output logic [PIX_W-1:0]  enc_y,
   output logic [PIX_W-1:0]  enc_cb,
   output logic [PIX_W-1:0]  enc_cr,
   output logic [PIX_W-1:0]  rgb_y,
   output logic [PIX_W-1:0]  rgb_cb,
   output logic [PIX_W-1:0]  rgb_cr,
   output logic              out_act
);
   ycc_t              main_px;
   ycc_t              ovl_px;
   ycc_t              bar_px;
   ycc_t              enc_px;
   ycc_t              rgb_px;
   mix_ctrl_t         ctrl;
   logic [CODE_W-1:0] bar_idx;
   logic              key_hit;
   logic              enc_off;
   logic              act_q;
   logic              armed_q;

   assign main_px = '{y: pix_y, cb: pix_cb, cr: pix_cr};
   assign key_hit = key_in ^ ctrl.key_inv;

   if (ENC_GATE_EN) begin : g_enc_gate
      assign enc_off = ctrl.enc_key_off;
   end else begin : g_enc_free
      assign enc_off = 1'b0;
   end

   ovm_lut #(.NCOL(NCOL), .ADDR_W(ADDR_W)) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .code_a (ovl_code),
      .idx_b  (bar_idx),
      .ent_a  (ovl_px),
      .ent_b  (bar_px),
      .ctrl   (ctrl)
   );

   ovm_bar_seq #(.NCOL(NCOL), .ACT_PIX(ACT_PIX)) u_bar (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (pix_act),
      .idx   (bar_idx)
   );

   ovm_path_sel u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (pix_act),
      .key_hit (key_hit),
      .key_off (enc_off),
      .bar_en  (ctrl.bar_en),
      .main_px (main_px),
      .ovl_px  (ovl_px),
      .bar_px  (bar_px),
      .out_px  (enc_px)
   );

   ovm_path_sel u_rgb (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (pix_act),
      .key_hit (key_hit),
      .key_off (1'b0),
      .bar_en  (ctrl.bar_en),
      .main_px (main_px),
      .ovl_px  (ovl_px),
      .bar_px  (bar_px),
      .out_px  (rgb_px)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         act_q   <= pix_act;
         armed_q <= 1'b1;
      end
   end

   assign out_act = act_q;
   assign enc_y   = enc_px.y;
   assign enc_cb  = enc_px.cb;
   assign enc_cr  = enc_px.cr;
   assign rgb_y   = rgb_px.y;
   assign rgb_cb  = rgb_px.cb;
   assign rgb_cr  = rgb_px.cr;

   // R6
   path_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && (enc_px != rgb_px)
      |-> $past(ctrl.enc_key_off) && $past(pix_act) && !$past(ctrl.bar_en));
endmodule

// File: tb/test_ovl_key_mixer.sv
module test_ovl_key_mixer;
   localparam int ACT = 48;
   localparam int STEP = ACT / 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pix_y = '0, pix_cb = '0, pix_cr = '0;
   logic       pix_act = 1'b0, key_in = 1'b0;
   logic [2:0] ovl_code = '0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] enc_y, enc_cb, enc_cr, rgb_y, rgb_cb, rgb_cr;
   logic       out_act;

   int total = 0;
   int bad = 0;

   logic [7:0] tm [24];
   logic [2:0] cm;
   logic       bm_prev;
   int         bm_pos;

   ovl_key_mixer #(.NCOL(8), .ACT_PIX(ACT)) i_ovl_key_mixer (
      .clk(clk), .rst_n(rst_n),
      .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
      .pix_act(pix_act), .key_in(key_in), .ovl_code(ovl_code),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .enc_y(enc_y), .enc_cb(enc_cb), .enc_cr(enc_cr),
      .rgb_y(rgb_y), .rgb_cb(rgb_cb), .rgb_cr(rgb_cr),
      .out_act(out_act)
   );

   always #2 clk = ~clk;

   function automatic logic [23:0] entry(input int c);
      return {tm[3*c], tm[3*c+1], tm[3*c+2]};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [24:0] act_v, input logic [24:0] exp_v);
      total++;
      if (act_v !== exp_v) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act_v, exp_v);
      end
   endtask

   task automatic drive(input string tag, input logic [23:0] px, input logic act,
                        input logic key, input logic [2:0] code,
                        input logic we, input logic [4:0] addr, input logic [7:0] wd);
      logic [23:0] e_rgb, e_enc;
      int pos, bi;
      @(negedge clk);
      {pix_y, pix_cb, pix_cr} = px;
      pix_act = act; key_in = key; ovl_code = code;
      cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
      e_rgb = px; e_enc = px;
      pos = (act && !bm_prev) ? 0 : bm_pos;
      if (act) begin
         if (cm[2]) begin
            bi = pos / STEP;
            if (bi > 7) bi = 7;
            e_rgb = entry(bi); e_enc = entry(bi);
         end else if (key ^ cm[0]) begin
            e_rgb = entry(int'(code));
            if (!cm[1]) e_enc = entry(int'(code));
         end
      end
      bm_prev = act;
      if (act) bm_pos = pos + 1;
      if (we) begin
         if (addr < 5'd24) tm[addr] = wd;
         else if (addr == 5'd24) cm = wd[2:0];
      end
      @(posedge clk);
      #1;
      check(tag, "rgb", {1'b0, rgb_y, rgb_cb, rgb_cr}, {1'b0, e_rgb});
      check(tag, "enc", {out_act, enc_y, enc_cb, enc_cr}, {act, e_enc});
   endtask

   task automatic wr(input string tag, input logic [4:0] a, input logic [7:0] d);
      drive(tag, 24'h0, 1'b0, 1'b0, 3'd0, 1'b1, a, d);
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs zero during reset
      check("R1", "in reset", {out_act, rgb_y, rgb_cb, rgb_cr, enc_y}, 33'h0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: table reads zero after release
      drive("R1", 24'h336699, 1'b1, 1'b1, 3'd5, 1'b0, 5'd0, 8'd0);
      drive("R1", 24'h112233, 1'b0, 1'b0, 3'd0, 1'b0, 5'd0, 8'd0);
   endtask

   task automatic t_load_and_key;
      for (int i = 0; i < 24; i++) wr("R3", 5'(i), 8'(8'h10 + i * 7));
      // R4: key high selects table entry per code
      for (int c = 0; c < 8; c++)
         drive("R4", {8'(c), 8'hA0, 8'h5F}, 1'b1, 1'b1, 3'(c), 1'b0, 5'd0, 8'd0);
      // R4: key low keeps main video
      for (int c = 0; c < 4; c++)
         drive("R4", {8'h40, 8'(c), 8'h90}, 1'b1, 1'b0, 3'(c), 1'b0, 5'd0, 8'd0);
      // R2: latency across alternating key
      for (int c = 0; c < 6; c++)
         drive("R2", {8'(c * 9), 8'h22, 8'h33}, 1'b1, c[0], 3'(7 - c), 1'b0, 5'd0, 8'd0);
   endtask

   task automatic t_blank;
      // R9: blanking passes main despite key
      for (int c = 0; c < 4; c++)
         drive("R9", {8'hE0, 8'(c), 8'h0F}, 1'b0, 1'b1, 3'(c), 1'b0, 5'd0, 8'd0);
   endtask

   task automatic t_polarity;
      wr("R5", 5'd24, 8'h01);
      // R5: inverted key
      drive("R5", 24'h445566, 1'b1, 1'b0, 3'd3, 1'b0, 5'd0, 8'd0);
      drive("R5", 24'h445566, 1'b1, 1'b1, 3'd3, 1'b0, 5'd0, 8'd0);
      drive("R5", 24'h778899, 1'b1, 1'b0, 3'd6, 1'b0, 5'd0, 8'd0);
   endtask

   task automatic t_enc_gate;
      wr("R6", 5'd24, 8'h02);
      // R6: encoder keeps main, rgb overlays
      for (int c = 0; c < 4; c++)
         drive("R6", {8'h81, 8'(c), 8'h7E}, 1'b1, 1'b1, 3'(c * 2), 1'b0, 5'd0, 8'd0);
      drive("R6", 24'h818283, 1'b1, 1'b0, 3'd1, 1'b0, 5'd0, 8'd0);
   endtask

   task automatic t_bars;
      wr("R7", 5'd24, 8'h04);
      for (int ln = 0; ln < 2; ln++) begin
         // R7: eight steps per active line, then blanking
         for (int p = 0; p < ACT; p++)
            drive("R7", {8'(p), 8'h11, 8'h22}, 1'b1, p[1], 3'(p), 1'b0, 5'd0, 8'd0);
         for (int p = 0; p < 3; p++)
            drive("R9", {8'h99, 8'(p), 8'h01}, 1'b0, 1'b1, 3'd4, 1'b0, 5'd0, 8'd0);
      end
      // R7: long line holds last entry
      for (int p = 0; p < ACT + 4; p++)
         drive("R7", 24'h0A0B0C, 1'b1, 1'b0, 3'd0, 1'b0, 5'd0, 8'd0);
      drive("R7", 24'h0A0B0C, 1'b0, 1'b0, 3'd0, 1'b0, 5'd0, 8'd0);
      wr("R8", 5'd24, 8'h07);
      // R8: bars ignore key, polarity, encoder key-off, main data
      for (int p = 0; p < ACT; p++)
         drive("R8", {8'(p * 3), 8'(~p), 8'h5A}, 1'b1, p[0], 3'(p * 5), 1'b0, 5'd0, 8'd0);
      drive("R8", 24'h010203, 1'b0, 1'b1, 3'd2, 1'b0, 5'd0, 8'd0);
   endtask

   task automatic t_write_timing;
      wr("R3", 5'd24, 8'h00);
      // R3: write collides with keyed pixel using entry 2
      drive("R3", 24'h000000, 1'b1, 1'b1, 3'd2, 1'b1, 5'd7, 8'hC3);
      drive("R3", 24'h000000, 1'b1, 1'b1, 3'd2, 1'b0, 5'd0, 8'd0);
      drive("R3", 24'h000000, 1'b1, 1'b1, 3'd7, 1'b1, 5'd21, 8'h3C);
      drive("R3", 24'h000000, 1'b1, 1'b1, 3'd7, 1'b0, 5'd0, 8'd0);
   endtask

   task automatic t_bad_addr;
      for (int a = 25; a < 32; a++) wr("R10", 5'(a), 8'hFF);
      // R10: table and control unchanged
      for (int c = 0; c < 8; c++)
         drive("R10", 24'h123456, 1'b1, 1'b1, 3'(c), 1'b0, 5'd0, 8'd0);
      drive("R10", 24'h654321, 1'b1, 1'b0, 3'd1, 1'b0, 5'd0, 8'd0);
   endtask

   task automatic finish_run;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 24; i++) tm[i] = 8'h00;
      cm = 3'b000;
      bm_prev = 1'b0;
      bm_pos = 0;
      t_reset;
      t_load_and_key;
      t_blank;
      t_polarity;
      t_enc_gate;
      t_bars;
      t_write_timing;
      t_bad_addr;
      finish_run;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run;
   end
endmodule